// File: doc/BRIEF.md
# Stop Mode Wake-up Controller

This block controls how a small microcontroller leaves its clock-halted stop state. When the CPU asks for stop, the block drops its clock-enable output and holds it low. It watches for two kinds of wake event. One is the system reset input. The other is a pending interrupt from a source whose level field is not the disabled code 3'b111.

A wake event does not restart the clock at once. The oscillator needs time to settle, so the block first counts a stabilization interval on a free-running reference tick. Both wake paths share this one wait timer. When the interval runs out, clock-enable returns high. In that same cycle the block gives exactly one path indication:

- a reset-sequence start, after a reset wake; or
- a resume, after an interrupt wake. With the resume comes a flag that says whether the interrupt will be taken or whether execution simply continues after the stop instruction.

The interval lengths are powers of two of the reference tick. A parameter scales them down so that simulation stays short.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After the block's own reset (por_n low), clk_en is 1 and reset_seq_start, resume and take_irq are 0.
- R2: While running, stop_req high at a clock edge makes clk_en 0 from that edge on.
- R3: While stopped, clk_en stays 0 and no pulse is given as long as sys_rst is low and no source has both its request bit set and its 3-bit level (bits 3i+2..3i of irq_lvl) different from 3'b111.
- R4: An interrupt wake uses the wait_sel value present at the wake edge. Codes 0, 1, 2 and 3 select 2^(10-SCALE), 2^(13-SCALE), 2^(15-SCALE) and 2^(17-SCALE) ticks. The wait ends on the edge that counts the last tick. On that edge clk_en rises and the pulse is issued.
- R5: A reset wake always uses the code-3 interval. Counting starts with the first tick after sys_rst falls. When the wait ends, reset_seq_start pulses and resume stays 0.
- R6: sys_rst high during a wait restarts the wait and turns it into a reset wake, even if the wait was started by an interrupt.
- R7: Only cycles with tick high advance the wait. With tick held low, the wait never ends.
- R8: Each wake ends with exactly one one-cycle pulse: reset_seq_start or resume, never both. take_irq is high only together with resume.
- R9: On resume, take_irq is ie_flag AND (winning level < lvl_mask), compared as 3-bit unsigned numbers. ie_flag and lvl_mask are sampled at the end edge. The winner is the qualifying source with the lowest level, and the lowest index breaks ties. Its level is captured at the wake edge.
- R10: stop_req during a wait has no effect. The wait ends at its normal time and clk_en stays 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low reset of the block itself |
| tick | input | 1 | Reference tick enable that advances the wait |
| stop_req | input | 1 | CPU request to enter stop |
| sys_rst | input | 1 | System reset input, a wake source |
| irq_req | input | NUM_SRC | Per-source interrupt request |
| irq_lvl | input | 3*NUM_SRC | Per-source level; 3'b111 disables the source |
| wait_sel | input | 2 | Stabilization length select for interrupt wakes |
| ie_flag | input | 1 | CPU global interrupt enable |
| lvl_mask | input | 3 | CPU level mask; a level strictly below it is accepted |
| clk_en | output | 1 | Clock enable, low while stopped or waiting |
| reset_seq_start | output | 1 | One-cycle pulse: start the reset sequence |
| resume | output | 1 | One-cycle pulse: leave stop after an interrupt wake |
| take_irq | output | 1 | With resume: the interrupt is taken |

## Verification
Interrupt wakes are swept over all four wait-select codes, each with the enable flag off and on. The measured latency tells each code's interval apart, and the enable flag is seen to gate take_irq. A second sweep runs every enabled level against every mask value. This pins the strict less-than comparison at each boundary, and a mixed set of sources shows that the lowest level wins.

Reset wakes are tried from the stopped state and in the middle of an interrupt wait. Both show the forced long interval and the switch to the reset path. Further cases cover disabled-level requests, tick held low and stop requests during a wait. Each of these must leave the output timing unchanged.

// File: rtl/swk_pkg.sv
package swk_pkg;
   localparam int SWK_LVL_W = 3;
   localparam logic [SWK_LVL_W-1:0] SWK_LVL_OFF = '1;

   typedef enum logic [1:0] {
      SWK_RUN  = 2'd0,
      SWK_STOP = 2'd1,
      SWK_WAIT = 2'd2
   } swk_state_e;

   // log2 of the unscaled settle length for each select code
   function automatic int swk_wait_exp(input logic [1:0] code);
      case (code)
         2'd0:    return 10;
         2'd1:    return 13;
         2'd2:    return 15;
         default: return 17;
      endcase
   endfunction
endpackage

// File: rtl/swk_irq_pick.sv
module swk_irq_pick
   import swk_pkg::*;
#(
   parameter int NUM_SRC = 4
) (
   input  logic [NUM_SRC-1:0]           req,
   input  logic [NUM_SRC*SWK_LVL_W-1:0] lvl,
   output logic                         hit,
   output logic [SWK_LVL_W-1:0]         best_lvl
);
   logic                 c_hit [NUM_SRC+1];
   logic [SWK_LVL_W-1:0] c_lvl [NUM_SRC+1];

   assign c_hit[0] = 1'b0;
   assign c_lvl[0] = SWK_LVL_OFF;

   // linear chain: strict compare keeps the lower index on equal levels
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_stage
      logic [SWK_LVL_W-1:0] my_lvl;
      logic                 qual, win;
      assign my_lvl = lvl[i*SWK_LVL_W +: SWK_LVL_W];
      assign qual   = req[i] && (my_lvl != SWK_LVL_OFF);
      assign win    = qual && (!c_hit[i] || (my_lvl < c_lvl[i]));
      assign c_hit[i+1] = c_hit[i] || qual;
      assign c_lvl[i+1] = win ? my_lvl : c_lvl[i];
   end

   assign hit      = c_hit[NUM_SRC];
   assign best_lvl = c_lvl[NUM_SRC];
endmodule

// File: rtl/swk_wait_timer.sv
module swk_wait_timer
   import swk_pkg::*;
#(
   parameter int SCALE = 0,
   parameter int CNT_W = 18 - SCALE
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       restart,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       done
);
   if (SCALE < 0 || SCALE > 10) begin : g_bad_scale
      $error("swk_wait_timer: SCALE must lie in 0..10");
   end
   if (CNT_W < 18 - SCALE) begin : g_bad_width
      $error("swk_wait_timer: CNT_W too narrow for longest wait");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   assign last = (CNT_W'(1) << (swk_wait_exp(sel) - SCALE)) - CNT_W'(1);
   assign done = run && (cnt == last);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (run)     cnt <= done ? '0 : cnt + CNT_W'(1);
   end
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
   import swk_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int SCALE   = 0,
   localparam int LVL_BITS = NUM_SRC * SWK_LVL_W
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 tick,
   input  logic                 stop_req,
   input  logic                 sys_rst,
   input  logic [NUM_SRC-1:0]   irq_req,
   input  logic [LVL_BITS-1:0]  irq_lvl,
   input  logic [1:0]           wait_sel,
   input  logic                 ie_flag,
   input  logic [SWK_LVL_W-1:0] lvl_mask,
   output logic                 clk_en,
   output logic                 reset_seq_start,
   output logic                 resume,
   output logic                 take_irq
);
   if (NUM_SRC < 1) begin : g_bad_src
      $error("stop_wake_ctrl: NUM_SRC must be at least 1");
   end

   swk_state_e           state;
   logic                 path_rst;
   logic [1:0]           sel_q;
   logic [SWK_LVL_W-1:0] lvl_q;
   logic                 irq_hit;
   logic [SWK_LVL_W-1:0] irq_best;
   logic                 restart, run, fin;

   swk_irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .req      (irq_req),
      .lvl      (irq_lvl),
      .hit      (irq_hit),
      .best_lvl (irq_best)
   );

   always_comb begin
      restart = 1'b0;
      case (state)
         SWK_STOP: restart = sys_rst || irq_hit;
         SWK_WAIT: restart = sys_rst;
         default:  restart = 1'b0;
      endcase
   end

   assign run = (state == SWK_WAIT) && tick && !sys_rst;

   swk_wait_timer #(.SCALE(SCALE)) u_timer (
      .clk     (clk),
      .por_n   (por_n),
      .restart (restart),
      .run     (run),
      .sel     (sel_q),
      .done    (fin)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state           <= SWK_RUN;
         path_rst        <= 1'b0;
         sel_q           <= 2'd3;
         lvl_q           <= '0;
         reset_seq_start <= 1'b0;
         resume          <= 1'b0;
         take_irq        <= 1'b0;
      end else begin
         reset_seq_start <= 1'b0;
         resume          <= 1'b0;
         take_irq        <= 1'b0;
         case (state)
            SWK_RUN: if (stop_req) state <= SWK_STOP;
            SWK_STOP: begin
               if (sys_rst) begin
                  state    <= SWK_WAIT;
                  path_rst <= 1'b1;
                  sel_q    <= 2'd3;
               end else if (irq_hit) begin
                  state    <= SWK_WAIT;
                  path_rst <= 1'b0;
                  sel_q    <= wait_sel;
                  lvl_q    <= irq_best;
               end
            end
            SWK_WAIT: begin
               if (sys_rst) begin
                  path_rst <= 1'b1;
                  sel_q    <= 2'd3;
               end else if (fin) begin
                  state <= SWK_RUN;
                  if (path_rst) reset_seq_start <= 1'b1;
                  else begin
                     resume   <= 1'b1;
                     take_irq <= ie_flag && (lvl_q < lvl_mask);
                  end
               end
            end
            default: state <= SWK_RUN;
         endcase
      end
   end

   assign clk_en = (state == SWK_RUN);
endmodule

module swk_chk (
   input logic clk,
   input logic por_n,
   input logic stop_req,
   input logic sys_rst,
   input logic clk_en,
   input logic reset_seq_start,
   input logic resume,
   input logic take_irq
);
   a_r2_stop_gates: assert property (@(posedge clk) disable iff (!por_n)
      (clk_en && stop_req) |=> !clk_en);
   a_r4_clk_with_end: assert property (@(posedge clk) disable iff (!por_n)
      $rose(clk_en) |-> (reset_seq_start || resume));
   a_r6_rst_holds_wait: assert property (@(posedge clk) disable iff (!por_n)
      (!clk_en && sys_rst) |=> (!clk_en && !reset_seq_start && !resume));
   a_r8_one_path: assert property (@(posedge clk) disable iff (!por_n)
      !(reset_seq_start && resume));
   a_r8_take_with_resume: assert property (@(posedge clk) disable iff (!por_n)
      take_irq |-> resume);
   a_r8_rst_pulse: assert property (@(posedge clk) disable iff (!por_n)
      reset_seq_start |=> !reset_seq_start);
   a_r8_resume_pulse: assert property (@(posedge clk) disable iff (!por_n)
      resume |=> !resume);
endmodule

bind stop_wake_ctrl swk_chk u_chk (
   .clk             (clk),
   .por_n           (por_n),
   .stop_req        (stop_req),
   .sys_rst         (sys_rst),
   .clk_en          (clk_en),
   .reset_seq_start (reset_seq_start),
   .resume          (resume),
   .take_irq        (take_irq)
);

// File: tb/sim_stop_wake_ctrl.sv
module sim_stop_wake_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC  = 4;
   localparam int SCL   = 8;

   logic            clk = 1'b0;
   logic            por_n = 1'b0;
   logic            tick = 1'b1;
   logic            stop_req = 1'b0;
   logic            sys_rst = 1'b0;
   logic [NSRC-1:0] irq_req = '0;
   logic [NSRC*3-1:0] irq_lvl = '1;
   logic [1:0]      wait_sel = 2'd0;
   logic            ie_flag = 1'b0;
   logic [2:0]      lvl_mask = 3'd0;
   logic            clk_en, reset_seq_start, resume, take_irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stop_wake_ctrl #(.NUM_SRC(NSRC), .SCALE(SCL)) u0 (
      .clk(clk), .por_n(por_n), .tick(tick), .stop_req(stop_req),
      .sys_rst(sys_rst), .irq_req(irq_req), .irq_lvl(irq_lvl),
      .wait_sel(wait_sel), .ie_flag(ie_flag), .lvl_mask(lvl_mask),
      .clk_en(clk_en), .reset_seq_start(reset_seq_start),
      .resume(resume), .take_irq(take_irq)
   );

   function automatic int wlen(input int code);
      int e;
      e = (code == 0) ? 10 : (code == 1) ? 13 : (code == 2) ? 15 : 17;
      return 1 << (e - SCL);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic enter_stop();
      @(negedge clk) stop_req = 1'b1;
      @(negedge clk) stop_req = 1'b0;
      chk(clk_en == 1'b0, "R2 clk_en after stop", int'(clk_en), 0);
   endtask

   // counts negedge samples until a path pulse shows
   task automatic wait_pulse(input int maxc, output int n, output bit rs,
                             output bit rm, output bit ti, output bit ce);
      n = 0; rs = 0; rm = 0; ti = 0; ce = 0;
      for (int k = 0; k < maxc; k++) begin
         @(negedge clk);
         n++;
         if (reset_seq_start || resume) begin
            rs = reset_seq_start; rm = resume; ti = take_irq; ce = clk_en;
            break;
         end
      end
   endtask

   task automatic set_lvl(input int src, input int v);
      irq_lvl[src*3 +: 3] = 3'(v);
   endtask

   initial begin
      repeat (CLK_PERIOD * 200000) #1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      bit rs, rm, ti, ce, bad;
      repeat (3) @(negedge clk);
      chk(clk_en == 1'b1 && !reset_seq_start && !resume && !take_irq,
          "R1 reset state", int'(clk_en), 1);
      por_n = 1'b1;
      @(negedge clk);

      // R3: disabled or unrequested sources do not wake
      enter_stop();
      set_lvl(0, 7); set_lvl(1, 0);
      irq_req = 4'b0001;
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (clk_en || reset_seq_start || resume) bad = 1;
      end
      chk(!bad, "R3 no wake from level 7 or idle source", int'(bad), 0);
      irq_req = '0; irq_lvl = '1;

      // R4/R9: select codes with enable off and on; stop is still held from above
      for (int s = 0; s < 4; s++) begin
         for (int e = 0; e < 2; e++) begin
            if (clk_en) enter_stop();
            @(negedge clk);
            wait_sel = 2'(s); ie_flag = 1'(e); lvl_mask = 3'd4;
            set_lvl(1, 2); irq_req = 4'b0010;
            wait_pulse(2000, n, rs, rm, ti, ce);
            irq_req = '0;
            chk(n == wlen(s) + 1, "R4 wait length", n, wlen(s) + 1);
            chk(rm && !rs && ce, "R8 resume path only", int'(rm), 1);
            chk(ti == 1'(e), "R9 enable gates take", int'(ti), e);
            @(negedge clk);
            chk(!resume && !take_irq && clk_en, "R8 one-cycle pulse", int'(resume), 0);
         end
      end
      irq_lvl = '1;

      // R9: every level against every mask
      ie_flag = 1'b1; wait_sel = 2'd0;
      for (int l = 0; l < 7; l++) begin
         for (int m = 0; m < 8; m++) begin
            enter_stop();
            @(negedge clk);
            set_lvl(2, l); irq_req = 4'b0100; lvl_mask = 3'(m);
            wait_pulse(100, n, rs, rm, ti, ce);
            irq_req = '0;
            chk(rm && (ti == (l < m)), "R9 level vs mask", int'(ti), int'(l < m));
         end
      end
      irq_lvl = '1;

      // R9: lowest level wins among sources
      enter_stop();
      @(negedge clk);
      set_lvl(0, 6); set_lvl(2, 1); set_lvl(3, 5); irq_req = 4'b1101; lvl_mask = 3'd2;
      wait_pulse(100, n, rs, rm, ti, ce);
      irq_req = '0; irq_lvl = '1;
      chk(rm && ti, "R9 lowest level chosen", int'(ti), 1);

      // R5: reset wake uses longest wait from release
      enter_stop();
      wait_sel = 2'd0;
      @(negedge clk) sys_rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(!clk_en && !reset_seq_start, "R5 held while sys_rst", int'(clk_en), 0);
      sys_rst = 1'b0;
      wait_pulse(2000, n, rs, rm, ti, ce);
      chk(n == wlen(3), "R5 reset wait length", n, wlen(3));
      chk(rs && !rm && ce, "R5 reset path", int'(rs), 1);

      // R6: reset during interrupt wait forces reset path
      enter_stop();
      @(negedge clk);
      set_lvl(1, 0); irq_req = 4'b0010; wait_sel = 2'd0;
      repeat (2) @(negedge clk);
      irq_req = '0; sys_rst = 1'b1;
      @(negedge clk) sys_rst = 1'b0;
      wait_pulse(2000, n, rs, rm, ti, ce);
      irq_lvl = '1;
      chk(n == wlen(3), "R6 restarted long wait", n, wlen(3));
      chk(rs && !rm && !ti, "R6 reset path wins", int'(rs), 1);

      // R7: no ticks, no progress
      enter_stop();
      @(negedge clk);
      tick = 1'b0; set_lvl(0, 3); irq_req = 4'b0001; wait_sel = 2'd0;
      @(negedge clk) irq_req = '0;
      bad = 0;
      repeat (50) begin
         @(negedge clk);
         if (clk_en || resume || reset_seq_start) bad = 1;
      end
      chk(!bad, "R7 frozen without tick", int'(bad), 0);
      tick = 1'b1;
      wait_pulse(100, n, rs, rm, ti, ce);
      irq_lvl = '1;
      chk(n == wlen(0) && rm, "R7 counts only ticks", n, wlen(0));

      // R10: stop request during wait ignored
      enter_stop();
      @(negedge clk);
      set_lvl(3, 1); irq_req = 4'b1000; wait_sel = 2'd1;
      @(negedge clk) begin irq_req = '0; stop_req = 1'b1; end
      @(negedge clk) stop_req = 1'b0;
      wait_pulse(200, n, rs, rm, ti, ce);
      irq_lvl = '1;
      chk(n == wlen(1) - 1 && rm, "R10 wait unaffected", n, wlen(1) - 1);
      repeat (3) @(negedge clk);
      chk(clk_en == 1'b1, "R10 stays running", int'(clk_en), 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule